// File: doc/BRIEF.md
# Timer Interrupt Flag and Priority Controller

This block sits between two down-counting timers and the CPU's interrupt input. Each timer delivers a one-cycle underflow pulse. On that pulse the block latches a pending flag for the timer. The flag is latched whatever the enable and priority settings are, so software can poll it even when interrupts are off.

Software programs three things through a small register port: a per-timer enable mask, a shared 2-bit priority level, and write-one-to-clear on the pending flags. The block compares the programmed level with the CPU's current 2-bit mask level. It raises a request, with the level beside it, only when an enabled flag is pending and the level is strictly above that mask. When the two timers are chained into one 16-bit timer, the low timer's enable is ignored.

Register map on the 2-bit address. Address 0 holds the priority field in bits [1:0]. Address 1 holds the enables, with bit 0 for timer 0 and bit 1 for timer 1. Address 2 holds the pending flags, with the same bit order. Address 3 is unused.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset the priority field, the enable bits and both pending flags read 0, and `irqReq` is low.
- R2: An underflow pulse on `uflow[i]` sets pending flag i on the next clock edge, whatever the enable bits and priority are.
- R3: A write to address 2 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A read of address 2 returns the flags, bit i for timer i.
- R4: If a clearing write and an underflow for the same flag occur in the same cycle, the flag ends up set.
- R5: Priority code 2'b11 is level 3, 2'b10 is level 2, 2'b01 is level 1 and 2'b00 is level 0. Level 0 never raises `irqReq`.
- R6: `irqReq` is high exactly when some flag i is pending with its enable bit set and the priority level is strictly greater than `cpuMask`. It is low when the level equals the mask.
- R7: `irqLevel` equals the priority field while `irqReq` is high, and it is 0 otherwise. Both outputs follow input changes within the same cycle.
- R8: While `mode16` is high, timer 0's enable bit is treated as 0. Only a pending, enabled timer 1 flag can then raise a request. The stored enable bits are not altered.
- R9: A read of address 0 returns the priority field and a read of address 1 returns the enable bits. A read of address 3 returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wrData | input | 2 | Write data |
| rdData | output | 2 | Combinational read data for `addr` |
| uflow | input | 2 | Per-timer underflow pulses, bit i for timer i |
| mode16 | input | 1 | Timers chained into one 16-bit timer |
| cpuMask | input | 2 | CPU's current interrupt mask level |
| irqReq | output | 1 | Interrupt request |
| irqLevel | output | 2 | Level carried with the request |

## Verification
The hardest case to reach from the ports is a clearing write to the flag register that lands in the same edge as an underflow for that flag. The stimulus builds it by driving a write and an underflow pulse in one cycle, in two forms. In one the clear and the pulse hit the same timer. In the other the clear hits one timer while the pulse hits the other. The flags are then read back. The strict comparison against the mask is checked by moving `cpuMask` to the priority level and one step on each side of it.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int TMR_NUM = 2;
  localparam int PRIO_W  = 2;
  localparam int ADDR_W  = 2;
  localparam int REG_W   = (PRIO_W > TMR_NUM) ? PRIO_W : TMR_NUM;

  localparam logic [ADDR_W-1:0] ADDR_PRIO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(2);

  typedef struct packed {
    logic prioWr;
    logic enWr;
    logic flagClr;
  } regStb_t;
endpackage

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  regStb_t            stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [TMR_NUM-1:0] uflow,
  output logic [TMR_NUM-1:0] flags,
  output logic [TMR_NUM-1:0] enBits,
  output logic [PRIO_W-1:0]  prio,
  output logic [REG_W-1:0]   rdData
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio   <= '0;
      enBits <= '0;
    end else begin
      if (stb.prioWr) prio   <= wrData[PRIO_W-1:0];
      if (stb.enWr)   enBits <= wrData[TMR_NUM-1:0];
    end
  end

  for (genvar i = 0; i < TMR_NUM; i++) begin : g_flag
    logic clrHit;
    assign clrHit = stb.flagClr & wrData[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (uflow[i])  flags[i] <= 1'b1;
      else if (clrHit)    flags[i] <= 1'b0;
    end

    // R2 and R4: an underflow always leaves the flag set
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[i] |=> flags[i]);
    // R3: a clearing write without an underflow leaves the flag clear
    p_flag_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clrHit && !uflow[i]) |=> !flags[i]);
    // R3: with no underflow and no clear, the flag holds
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clrHit && !uflow[i]) |=> $stable(flags[i]));
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_PRIO: rdData[PRIO_W-1:0]  = prio;
      ADDR_EN:   rdData[TMR_NUM-1:0] = enBits;
      ADDR_FLAG: rdData[TMR_NUM-1:0] = flags;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tmr_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [TMR_NUM-1:0] flags,
  input  logic [TMR_NUM-1:0] enBits,
  input  logic [PRIO_W-1:0]  prio,
  input  logic               mode16,
  input  logic [PRIO_W-1:0]  cpuMask,
  output regStb_t            stb,
  output logic               irqReq,
  output logic [PRIO_W-1:0]  irqLevel
);

  always_comb begin
    stb.prioWr  = wrEn && (addr == ADDR_PRIO);
    stb.enWr    = wrEn && (addr == ADDR_EN);
    stb.flagClr = wrEn && (addr == ADDR_FLAG);
  end

  logic [TMR_NUM-1:0] effEn;
  logic               pendHit;
  logic               aboveMask;

  always_comb begin
    effEn = enBits;
    if (mode16) effEn[0] = 1'b0;
  end

  assign pendHit   = |(flags & effEn);
  assign aboveMask = (prio > cpuMask);
  assign irqReq    = pendHit && aboveMask;
  assign irqLevel  = irqReq ? prio : '0;

  // R5: level 0 never requests
  p_lvl0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prio == '0) |-> !irqReq);
  // R6: a request always sits strictly above the CPU mask
  p_above_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (irqLevel > cpuMask));
  // R6: nothing pending and enabled means no request
  p_need_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & enBits) == '0) |-> !irqReq);
  // R8: in chained mode only timer 1 can request
  p_mode16_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && !(flags[1] && enBits[1])) |-> !irqReq);

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [TMR_NUM-1:0] uflow,
  input  logic               mode16,
  input  logic [PRIO_W-1:0]  cpuMask,
  output logic               irqReq,
  output logic [PRIO_W-1:0]  irqLevel
);

  regStb_t            stb;
  logic [TMR_NUM-1:0] flags;
  logic [TMR_NUM-1:0] enBits;
  logic [PRIO_W-1:0]  prio;

  tmr_irq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .addr     (addr),
    .flags    (flags),
    .enBits   (enBits),
    .prio     (prio),
    .mode16   (mode16),
    .cpuMask  (cpuMask),
    .stb      (stb),
    .irqReq   (irqReq),
    .irqLevel (irqLevel)
  );

  tmr_irq_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .addr   (addr),
    .wrData (wrData),
    .uflow  (uflow),
    .flags  (flags),
    .enBits (enBits),
    .prio   (prio),
    .rdData (rdData)
  );

endmodule

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [1:0] wrData = 2'd0;
  logic [1:0] rdData;
  logic [1:0] uflow = 2'd0;
  logic       mode16 = 1'b0;
  logic [1:0] cpuMask = 2'd0;
  logic       irqReq;
  logic [1:0] irqLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  typedef struct packed {
    logic [1:0] rd;
    logic       req;
    logic [1:0] lvl;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .uflow(uflow), .mode16(mode16), .cpuMask(cpuMask),
    .irqReq(irqReq), .irqLevel(irqLevel)
  );

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nChecks++;
        if (rdData !== e.rd || irqReq !== e.req || irqLevel !== e.lvl) begin
          nFails++;
          $display("FAIL %s: rd=%0d req=%0d lvl=%0d expected rd=%0d req=%0d lvl=%0d",
                   t, rdData, irqReq, irqLevel, e.rd, e.req, e.lvl);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d, input logic [1:0] uf);
    wrEn = 1'b1; addr = a; wrData = d; uflow = uf;
    tick();
    wrEn = 1'b0; uflow = 2'd0;
  endtask

  task automatic pulse(input logic [1:0] uf);
    uflow = uf;
    tick();
    uflow = 2'd0;
  endtask

  task automatic expect_st(input logic [1:0] a, input logic [1:0] rd,
                           input logic req, input logic [1:0] lvl, input string tag);
    exp_t e;
    addr = a;
    e.rd = rd; e.req = req; e.lvl = lvl;
    expQ.push_back(e);
    tagQ.push_back(tag);
    tick();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    expect_st(2'd0, 2'd0, 1'b0, 2'd0, "R1 prio");
    expect_st(2'd1, 2'd0, 1'b0, 2'd0, "R1 enable");
    expect_st(2'd2, 2'd0, 1'b0, 2'd0, "R1 flags");

    // R2 flags set while disabled
    pulse(2'b01);
    expect_st(2'd2, 2'b01, 1'b0, 2'd0, "R2 timer0 flag");
    pulse(2'b10);
    expect_st(2'd2, 2'b11, 1'b0, 2'd0, "R2 timer1 flag");

    // R3 write-one-to-clear
    wr(2'd2, 2'b00, 2'b00);
    expect_st(2'd2, 2'b11, 1'b0, 2'd0, "R3 zero write no effect");
    wr(2'd2, 2'b01, 2'b00);
    expect_st(2'd2, 2'b10, 1'b0, 2'd0, "R3 clear timer0");
    wr(2'd2, 2'b10, 2'b00);
    expect_st(2'd2, 2'b00, 1'b0, 2'd0, "R3 clear timer1");

    // R9 readback and unused address
    wr(2'd0, 2'b11, 2'b00);
    expect_st(2'd0, 2'b11, 1'b0, 2'd0, "R9 prio readback");
    wr(2'd1, 2'b01, 2'b00);
    expect_st(2'd1, 2'b01, 1'b0, 2'd0, "R9 enable readback");
    wr(2'd3, 2'b10, 2'b00);
    expect_st(2'd3, 2'b00, 1'b0, 2'd0, "R9 addr3 reads 0");
    expect_st(2'd0, 2'b11, 1'b0, 2'd0, "R9 addr3 write left prio");
    expect_st(2'd1, 2'b01, 1'b0, 2'd0, "R9 addr3 write left enable");

    // R6/R7 requests vs mask
    cpuMask = 2'd0;
    pulse(2'b01);
    expect_st(2'd2, 2'b01, 1'b1, 2'd3, "R6 R7 level3 over mask0");
    cpuMask = 2'd2;
    expect_st(2'd2, 2'b01, 1'b1, 2'd3, "R6 level3 over mask2");
    cpuMask = 2'd3;
    expect_st(2'd2, 2'b01, 1'b0, 2'd0, "R6 R7 level equal mask");
    wr(2'd0, 2'b10, 2'b00);
    cpuMask = 2'd2;
    expect_st(2'd0, 2'b10, 1'b0, 2'd0, "R6 level2 equal mask2");
    cpuMask = 2'd1;
    expect_st(2'd0, 2'b10, 1'b1, 2'd2, "R6 R7 level2 over mask1");
    wr(2'd0, 2'b01, 2'b00);
    cpuMask = 2'd0;
    expect_st(2'd0, 2'b01, 1'b1, 2'd1, "R5 level1 over mask0");
    wr(2'd0, 2'b00, 2'b00);
    expect_st(2'd0, 2'b00, 1'b0, 2'd0, "R5 level0 never requests");
    wr(2'd0, 2'b11, 2'b00);
    wr(2'd1, 2'b10, 2'b00);
    expect_st(2'd2, 2'b01, 1'b0, 2'd0, "R6 pending but disabled");

    // R8 chained mode
    wr(2'd1, 2'b01, 2'b00);
    mode16 = 1'b1;
    expect_st(2'd1, 2'b01, 1'b0, 2'd0, "R8 timer0 enable ignored");
    wr(2'd1, 2'b11, 2'b00);
    expect_st(2'd2, 2'b01, 1'b0, 2'd0, "R8 timer0 flag only");
    pulse(2'b10);
    expect_st(2'd2, 2'b11, 1'b1, 2'd3, "R8 timer1 requests");
    wr(2'd2, 2'b10, 2'b00);
    expect_st(2'd2, 2'b01, 1'b0, 2'd0, "R8 timer1 cleared");
    mode16 = 1'b0;
    expect_st(2'd1, 2'b11, 1'b1, 2'd3, "R8 enable kept after chained mode");

    // R4 set wins over clear
    wr(2'd2, 2'b01, 2'b01);
    expect_st(2'd2, 2'b01, 1'b1, 2'd3, "R4 same-flag set wins");
    wr(2'd2, 2'b01, 2'b10);
    expect_st(2'd2, 2'b10, 1'b1, 2'd3, "R4 clear t0 with set t1");
    wr(2'd2, 2'b11, 2'b11);
    expect_st(2'd2, 2'b11, 1'b1, 2'd3, "R4 both set win");
    wr(2'd2, 2'b11, 2'b00);
    expect_st(2'd2, 2'b00, 1'b0, 2'd0, "R3 clear both");

    // let monitor drain
    tick();
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule